// File: doc/BRIEF.md
# PLL Reconfiguration Command Queue

This block is the management-side endpoint of a reconfigurable clock generator. A host writes reconfiguration commands, each an address and a data word, through a memory-mapped write port that has a write strobe and a waitrequest. The block does not apply a command when it arrives. It holds the command in a small internal queue until the host writes to address zero.

The write to address zero is the trigger. It raises waitrequest, then drains the queued commands in arrival order, one per clock, onto a parameter-register apply port. Each drained command carries a class tag: counter setting, loop-bandwidth setting or phase step. Waitrequest drops once the last command has been presented, and the queue is then empty.

A command written while the queue is full is discarded, and a sticky overflow flag records the loss. The next trigger clears that flag.

Top module: `pll_cmd_queue`

## Requirements
- R1: A write with a nonzero address, accepted while waitrequest is low, is stored in the queue. Stored commands are later applied in the order they were written, with their address and data unchanged.
- R2: The queue holds up to 8 commands (DEPTH). A further nonzero-address write to a full queue is discarded and sets the overflow flag `cfg_ovf`. The flag stays set while further writes arrive.
- R3: A write to address 9'h000 is the trigger. Its write data has no effect, and it is never queued. `mm_waitreq` is high in the cycle after the trigger is accepted.
- R4: After a trigger, each clock presents one queued command on `apply_addr`/`apply_data`, with `apply_valid` high. The first command appears in the first cycle after the trigger. `apply_valid` is only ever high while `mm_waitreq` is high.
- R5: `mm_waitreq` returns low in the cycle after the last queued command has been presented. The queue is then empty, so a later trigger with no new writes applies nothing.
- R6: `apply_class` gives the class of the command being applied. It is 2'd1 (bandwidth) for addresses 0x020 (charge pump) and 0x040 (loop filter). It is 2'd0 (counter) for 0x090 (feedback M), 0x0A0 (pre-divider N) and 0x0C0+k for outputs k = 0..8. It is 2'd2 (phase step) for every other nonzero address.
- R7: A write presented while `mm_waitreq` is high is stalled and not taken. If the host holds the write, it is accepted in the first cycle in which waitrequest is low, and it is then queued normally.
- R8: A trigger with an empty queue raises `mm_waitreq` for exactly one cycle and presents no `apply_valid`.
- R9: A trigger clears `cfg_ovf`, and the flag reads low from the next cycle on.
- R10: After reset, `mm_waitreq`, `apply_valid` and `cfg_ovf` are low and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mm_addr | input | 9 | Write address; 0 is the trigger |
| mm_wdata | input | 32 | Write data |
| mm_write | input | 1 | Write strobe |
| mm_waitreq | output | 1 | High while a reconfiguration is in progress; stalls writes |
| apply_valid | output | 1 | A command is being applied this cycle |
| apply_addr | output | 9 | Parameter-register address of the applied command |
| apply_data | output | 32 | Data of the applied command |
| apply_class | output | 2 | 0 counter, 1 bandwidth, 2 phase step |
| cfg_ovf | output | 1 | Sticky queue-overflow flag |

## Verification
The hardest case to reach is a write that arrives while the queue is draining. The stimulus issues a trigger and, in the very next cycle, presents a command with the strobe held. The bench must show three things:
- the command is not mixed into the current apply sequence;
- it is taken only when waitrequest falls;
- it is applied after the following trigger.

Overflow is reached by writing nine commands back to back. The bench confirms that only the first eight are applied and that the flag clears after the trigger.

// File: rtl/pll_cmd_queue.sv
module pll_cmd_queue #(
  parameter int AW      = 9,
  parameter int DW      = 32,
  parameter int DEPTH   = 8,
  parameter int NUM_OUT = 9,
  parameter logic [8:0] A_CP = 9'h020,
  parameter logic [8:0] A_LF = 9'h040,
  parameter logic [8:0] A_M  = 9'h090,
  parameter logic [8:0] A_N  = 9'h0A0,
  parameter logic [8:0] A_C0 = 9'h0C0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] mm_addr,
  input  logic [DW-1:0] mm_wdata,
  input  logic          mm_write,
  output logic          mm_waitreq,
  output logic          apply_valid,
  output logic [AW-1:0] apply_addr,
  output logic [DW-1:0] apply_data,
  output logic [1:0]    apply_class,
  output logic          cfg_ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] CLS_CNT = 2'd0;
  localparam logic [1:0] CLS_BW  = 2'd1;
  localparam logic [1:0] CLS_PH  = 2'd2;

  logic [AW-1:0] q_addr [DEPTH];
  logic [DW-1:0] q_data [DEPTH];
  logic [CW-1:0] count;
  logic [PW-1:0] rd_ptr;
  logic          busy;

  wire accept  = mm_write && !busy;
  wire trigger = accept && (mm_addr == '0);
  wire full    = (count == CW'(DEPTH));
  wire push    = accept && !trigger && !full;
  wire drop    = accept && !trigger && full;
  wire last    = (count == '0) || ((CW'(rd_ptr) + CW'(1)) >= count);

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[count[PW-1:0]] <= mm_addr;
      q_data[count[PW-1:0]] <= mm_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      rd_ptr <= '0;
      busy   <= 1'b0;
      cfg_ovf <= 1'b0;
    end else begin
      if (trigger) begin
        busy    <= 1'b1;
        rd_ptr  <= '0;
        cfg_ovf <= 1'b0;
      end else if (busy) begin
        if (last) begin
          busy   <= 1'b0;
          count  <= '0;
          rd_ptr <= '0;
        end else begin
          rd_ptr <= rd_ptr + PW'(1);
        end
      end else begin
        if (push) count <= count + CW'(1);
        if (drop) cfg_ovf <= 1'b1;
      end
    end
  end

  assign mm_waitreq  = busy;
  assign apply_valid = busy && (count != '0);
  assign apply_addr  = q_addr[rd_ptr];
  assign apply_data  = q_data[rd_ptr];

  wire is_bw  = (apply_addr == A_CP) || (apply_addr == A_LF);
  wire is_out = (int'(apply_addr) >= int'(A_C0)) && (int'(apply_addr) < int'(A_C0) + NUM_OUT);
  wire is_cnt = (apply_addr == A_M) || (apply_addr == A_N) || is_out;
  assign apply_class = is_bw ? CLS_BW : (is_cnt ? CLS_CNT : CLS_PH);

  AST_WAIT_ON_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> mm_waitreq); // R3
  AST_APPLY_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    apply_valid |-> mm_waitreq); // R4
  AST_DRAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_valid && last) |=> (!mm_waitreq && count == '0)); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (cfg_ovf && full)); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R2
  AST_STALL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> count <= $past(count)); // R7
  AST_EMPTY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && count == '0) |=> !mm_waitreq); // R8
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> !cfg_ovf); // R9
  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    apply_valid |-> apply_class != 2'd3); // R6
endmodule

// File: tb/pll_cmd_queue_tb.sv
module pll_cmd_queue_tb_top;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0;
  logic [8:0] mm_addr = '0;
  logic [31:0] mm_wdata = '0;
  logic mm_write = 0;
  logic mm_waitreq, apply_valid, cfg_ovf;
  logic [8:0] apply_addr;
  logic [31:0] apply_data;
  logic [1:0] apply_class;

  int n_chk = 0, n_bad = 0, mcount = 0;
  bit done = 0;
  logic [42:0] sb [$];

  always #(CLK_P/2) clk = ~clk;

  pll_cmd_queue dut_i (.clk(clk), .rst_n(rst_n), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .mm_write(mm_write), .mm_waitreq(mm_waitreq), .apply_valid(apply_valid),
    .apply_addr(apply_addr), .apply_data(apply_data), .apply_class(apply_class),
    .cfg_ovf(cfg_ovf));

  function automatic logic [1:0] cls_of(logic [8:0] a);
    if (a == 9'h020 || a == 9'h040) return 2'd1;
    if (a == 9'h090 || a == 9'h0A0 || (a >= 9'h0C0 && a <= 9'h0C8)) return 2'd0;
    return 2'd2;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && apply_valid) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R4: actual apply %0h expected none", apply_addr);
      end else begin
        logic [42:0] e;
        e = sb.pop_front();
        if ({apply_class, apply_addr, apply_data} !== e) begin
          n_bad++;
          $display("FAIL R1/R6: actual %0h expected %0h", {apply_class, apply_addr, apply_data}, e);
        end
      end
    end
  end

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    mm_addr = a; mm_wdata = d; mm_write = 1;
    while (mm_waitreq) @(negedge clk);
    @(posedge clk);
    if (a != 0) begin
      if (mcount < 8) begin
        sb.push_back({cls_of(a), a, d});
        mcount++;
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    mm_write = 0;
  endtask

  task automatic trig_run(logic [31:0] junk, string req);
    int exp_n, hi;
    exp_n = (mcount == 0) ? 1 : mcount;
    wr(9'h000, junk);
    mcount = 0;
    idle();
    hi = 0;
    chk(mm_waitreq === 1'b1, "R3", mm_waitreq, 1);
    while (mm_waitreq) begin
      hi++;
      @(negedge clk);
    end
    chk(hi == exp_n, req, hi, exp_n);
    chk(sb.size() == 0, "R5", sb.size(), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(mm_waitreq === 0, "R10", mm_waitreq, 0);
    chk(apply_valid === 0, "R10", apply_valid, 0);
    chk(cfg_ovf === 0, "R10", cfg_ovf, 0);

    // R8: empty trigger
    trig_run(32'hDEAD_BEEF, "R8");

    // R1 R6: mixed classes
    wr(9'h090, 32'h0000_0F0F); wr(9'h0A0, 32'h0001_0000);
    wr(9'h0C0, 32'h0000_0303); wr(9'h0C8, 32'h0000_1E1E);
    wr(9'h020, 32'h0000_0010); wr(9'h040, 32'h0000_0100);
    wr(9'h0C9, 32'h1234_5678); wr(9'h100, 32'hCAFE_0001);
    idle();
    chk(cfg_ovf === 0, "R2", cfg_ovf, 0);
    trig_run(32'hFFFF_FFFF, "R4");

    // R5: queue empty afterwards
    trig_run(32'h0, "R5");

    // R2 overflow, R9 clear
    for (int i = 0; i < 8; i++) wr(9'h0C1 + 9'(i), 32'hA000_0000 + i);
    idle();
    chk(cfg_ovf === 0, "R2", cfg_ovf, 0);
    wr(9'h01F, 32'hBAD0_0009);
    idle();
    chk(cfg_ovf === 1, "R2", cfg_ovf, 1);
    wr(9'h033, 32'hBAD0_000A);
    idle();
    chk(cfg_ovf === 1, "R2", cfg_ovf, 1);
    trig_run(32'h5555_AAAA, "R5");
    chk(cfg_ovf === 0, "R9", cfg_ovf, 0);

    // R7: write held during drain
    wr(9'h0A0, 32'h0000_0002); wr(9'h020, 32'h0000_000B);
    wr(9'h000, 32'h0);
    mcount = 0;
    wr(9'h0C1, 32'h0000_1414);
    idle();
    chk(mm_waitreq === 0, "R7", mm_waitreq, 0);
    chk(sb.size() == 1, "R7", sb.size(), 1);
    trig_run(32'h1, "R7");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule